// File: doc/BRIEF.md
# Block Address Translation Unit

This unit turns an effective address into a physical address for large, aligned memory regions without any table walk. It holds four mapping entries for instruction accesses and four for data accesses. Each entry is a pair of 32-bit words: an upper word with the effective base, region length and per-mode valid bits, and a lower word with the physical base, storage attributes and access rights. Software loads the words one at a time through a write port. After reset every entry is invalid.

Every cycle the unit looks up the presented effective address on the chosen side and reports, without a clock delay, whether an entry matched, the physical address, the four storage attribute bits and whether the access breaks the entry's write protection. A second, independent port runs the other way: it takes a physical address and returns the effective address that the data-side entries map onto it, or zero. A miss is only reported; resolving it is left to the rest of the memory system.

Top module: `bat_unit`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid: no lookup hits and the reverse port returns zero until entries are written again.
- R2: A write with `wr_en` high stores `wr_data` as a whole word into the entry selected by `wr_idx`, on the instruction side when `wr_iside` is 1 (data side when 0), into the lower word when `wr_lower` is 1 (upper word when 0). A lookup uses only the side selected by `iside`.
- R3: An entry takes part in a lookup only when its valid bit for the current mode is set: upper-word bit 1 when `sup` is 1, upper-word bit 0 when `sup` is 0.
- R4: The upper word holds the effective base in bits 31:17 and a length field L in bits 12:2; the region spans base to base + (L+1)*128 KiB - 1 inclusive, for region sizes from 128 KiB (L=0) to 256 MiB (L=2047).
- R5: On a hit, `pa` equals the physical base (lower-word bits 31:17) plus the offset of `ea` from the effective base; bits 16:0 pass through unchanged.
- R6: When several entries match, the one with the lowest index wins.
- R7: On a hit, `wimg` carries lower-word bits 6:3 in the order {write-through, cache-inhibit, coherent, guarded}.
- R8: Lower-word bit 1 set grants read-write access; clear means read-only with execute. An access with `acc` = 2'b01 (write) that hits a read-only entry raises `prot_fault` while still reporting the hit and translated address; reads (2'b00) and fetches (2'b10) never fault.
- R9: An instruction-side entry whose guarded bit (lower-word bit 3) is set never hits.
- R10: `rea` returns, from the lowest-indexed data-side entry with either valid bit set whose physical window holds `rpa`, the effective base plus the offset of `rpa` in that window; it is zero when no entry matches.
- R11: On a miss `hit`, `pa`, `wimg` and `prot_fault` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register word write strobe |
| wr_idx | input | 2 | Entry index of the write |
| wr_iside | input | 1 | Write targets the instruction side |
| wr_lower | input | 1 | Write targets the lower word |
| wr_data | input | 32 | Word to store |
| ea | input | 32 | Effective address to translate |
| sup | input | 1 | Supervisor mode (1) or user mode (0) |
| acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| iside | input | 1 | Look up the instruction side |
| hit | output | 1 | An entry matched |
| pa | output | 32 | Translated physical address |
| wimg | output | 4 | Storage attributes of the matching entry |
| prot_fault | output | 1 | Write to a read-only entry |
| rpa | input | 32 | Physical address for the reverse lookup |
| rea | output | 32 | Effective address from the reverse lookup, or zero |

## Verification
The assertions take for granted that every base written into an entry is aligned to its region size, so that masking and adding give the same address, and that `acc` never carries the unused code 2'b11. The stimulus programs only size-aligned bases and uses only the three defined access codes. The reset-state property relies on the inputs being driven to known values from time zero, which the stimulus does before the first clock edge.

// File: rtl/bat_pkg.sv
// Shared widths, field positions and types for the block address translation unit.
// Assumes 32-bit addresses and a smallest region of 128 KiB.
package bat_pkg;
    localparam int ADDR_W    = 32;
    localparam int BLK_SHIFT = 17;                  // log2 of the smallest region
    localparam int TAG_W     = ADDR_W - BLK_SHIFT;  // compared upper address bits
    localparam int BL_W      = 11;                  // length field width
    localparam int BL_LSB    = 2;                   // length field position in upper word
    localparam int VS_BIT    = 1;                   // supervisor valid
    localparam int VU_BIT    = 0;                   // user valid
    localparam int ATTR_LSB  = 3;                   // {W,I,M,G} at bits 6:3
    localparam int ATTR_W    = 4;
    localparam int G_BIT     = ATTR_LSB;            // guarded bit
    localparam int RW_BIT    = 1;                   // read-write grant
    localparam int FWD_W     = ADDR_W + ATTR_W + 1; // {pa, attrs, rw}

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_e;

    typedef struct packed {
        logic [ADDR_W-1:0] upper;
        logic [ADDR_W-1:0] lower;
    } bat_pair_t;
endpackage

// File: rtl/bat_regs.sv
// Mapping register storage: two banks (data, instruction) of N_ENT word pairs.
// One whole word is written per cycle; reset clears every word, so all valid bits drop.
module bat_regs
    import bat_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_iside,
    input  logic                    wr_lower,
    input  logic [ADDR_W-1:0]       wr_data,
    output bat_pair_t [N_ENT-1:0]   d_pairs,
    output bat_pair_t [N_ENT-1:0]   i_pairs
);
    bat_pair_t [N_ENT-1:0] bank_d;
    bat_pair_t [N_ENT-1:0] bank_i;

    // Store one word into the selected bank, entry and half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_d <= '0;
            bank_i <= '0;
        end else if (wr_en) begin
            if (wr_iside) begin
                if (wr_lower) bank_i[wr_idx].lower <= wr_data;
                else          bank_i[wr_idx].upper <= wr_data;
            end else begin
                if (wr_lower) bank_d[wr_idx].lower <= wr_data;
                else          bank_d[wr_idx].upper <= wr_data;
            end
        end
    end

    assign d_pairs = bank_d;
    assign i_pairs = bank_i;
endmodule

// File: rtl/bat_fwd_match.sv
// Forward comparators: one per entry, each tests the effective address against the
// entry's masked base and builds that entry's translation. Assumes size-aligned bases.
module bat_fwd_match
    import bat_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  bat_pair_t [N_ENT-1:0]          pairs,
    input  logic [ADDR_W-1:0]              ea,
    input  logic                           sup,
    input  logic                           fetch_side,
    output logic [N_ENT-1:0]               hits,
    output logic [N_ENT-1:0][FWD_W-1:0]    res
);
    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        logic [BL_W-1:0]  bl;
        logic [TAG_W-1:0] msk;
        logic             vld;
        logic             tag_eq;
        logic             gblock;
        logic [TAG_W-1:0] pa_tag;
        logic             unused_k;

        assign bl     = pairs[k].upper[BL_LSB +: BL_W];
        assign msk    = {{(TAG_W-BL_W){1'b0}}, bl};
        assign vld    = sup ? pairs[k].upper[VS_BIT] : pairs[k].upper[VU_BIT];
        assign tag_eq = ((ea[ADDR_W-1:BLK_SHIFT] ^ pairs[k].upper[ADDR_W-1:BLK_SHIFT]) & ~msk) == '0;
        assign gblock = fetch_side & pairs[k].lower[G_BIT];
        assign pa_tag = (pairs[k].lower[ADDR_W-1:BLK_SHIFT] & ~msk)
                      | (ea[ADDR_W-1:BLK_SHIFT] & msk);

        assign hits[k] = vld & tag_eq & ~gblock;
        assign res[k]  = {pa_tag, ea[BLK_SHIFT-1:0],
                          pairs[k].lower[ATTR_LSB +: ATTR_W],
                          pairs[k].lower[RW_BIT]};

        assign unused_k = ^{pairs[k].upper[BLK_SHIFT-1:BL_LSB+BL_W],
                            pairs[k].lower[BLK_SHIFT-1:ATTR_LSB+ATTR_W],
                            pairs[k].lower[ATTR_LSB-1:RW_BIT+1],
                            pairs[k].lower[RW_BIT-1:0]};
    end
endmodule

// File: rtl/bat_rev_match.sv
// Reverse comparators: one per data-side entry, each tests a physical address against
// the entry's physical window and rebuilds the effective address. Either valid bit enables.
module bat_rev_match
    import bat_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  bat_pair_t [N_ENT-1:0]           pairs,
    input  logic [ADDR_W-1:0]               rpa,
    output logic [N_ENT-1:0]                hits,
    output logic [N_ENT-1:0][ADDR_W-1:0]    res
);
    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        logic [TAG_W-1:0] msk;
        logic             vld;
        logic             in_win;
        logic [TAG_W-1:0] ea_tag;
        logic             unused_k;

        assign msk    = {{(TAG_W-BL_W){1'b0}}, pairs[k].upper[BL_LSB +: BL_W]};
        assign vld    = pairs[k].upper[VS_BIT] | pairs[k].upper[VU_BIT];
        assign in_win = ((rpa[ADDR_W-1:BLK_SHIFT] ^ pairs[k].lower[ADDR_W-1:BLK_SHIFT]) & ~msk) == '0;
        assign ea_tag = (pairs[k].upper[ADDR_W-1:BLK_SHIFT] & ~msk)
                      | (rpa[ADDR_W-1:BLK_SHIFT] & msk);

        assign hits[k] = vld & in_win;
        assign res[k]  = {ea_tag, rpa[BLK_SHIFT-1:0]};

        assign unused_k = ^{pairs[k].upper[BLK_SHIFT-1:BL_LSB+BL_W],
                            pairs[k].lower[BLK_SHIFT-1:0]};
    end
endmodule

// File: rtl/bat_pick.sv
// Fixed-priority selector: returns the payload of the lowest-indexed requester,
// or all zeros when nobody requests.
module bat_pick #(
    parameter int N_ENT = 4,
    parameter int W     = 32
) (
    input  logic [N_ENT-1:0]           req,
    input  logic [N_ENT-1:0][W-1:0]    pay,
    output logic                       any,
    output logic [W-1:0]               sel
);
    // Walk from the highest index down so the lowest matching index is kept.
    always_comb begin
        sel = '0;
        for (int k = N_ENT - 1; k >= 0; k--) begin
            if (req[k]) sel = pay[k];
        end
    end

    assign any = |req;
endmodule

// File: rtl/bat_unit.sv
// Block address translation unit top: register banks, forward lookup on the chosen
// side with first-match priority and write protection, and data-side reverse lookup.
// Results are combinational from the current inputs and stored entries.
module bat_unit
    import bat_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_iside,
    input  logic                wr_lower,
    input  logic [ADDR_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   ea,
    input  logic                sup,
    input  logic [1:0]          acc,
    input  logic                iside,
    output logic                hit,
    output logic [ADDR_W-1:0]   pa,
    output logic [ATTR_W-1:0]   wimg,
    output logic                prot_fault,
    input  logic [ADDR_W-1:0]   rpa,
    output logic [ADDR_W-1:0]   rea
);
    bat_pair_t [N_ENT-1:0]          d_pairs;
    bat_pair_t [N_ENT-1:0]          i_pairs;
    bat_pair_t [N_ENT-1:0]          look_pairs;
    logic [N_ENT-1:0]               fwd_hits;
    logic [N_ENT-1:0][FWD_W-1:0]    fwd_res;
    logic [FWD_W-1:0]               fwd_sel;
    logic [N_ENT-1:0]               rev_hits;
    logic [N_ENT-1:0][ADDR_W-1:0]   rev_res;
    logic                           rev_any;
    logic                           sel_rw;

    bat_regs #(.N_ENT(N_ENT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_iside (wr_iside),
        .wr_lower (wr_lower),
        .wr_data  (wr_data),
        .d_pairs  (d_pairs),
        .i_pairs  (i_pairs)
    );

    assign look_pairs = iside ? i_pairs : d_pairs;

    bat_fwd_match #(.N_ENT(N_ENT)) u_fwd (
        .pairs      (look_pairs),
        .ea         (ea),
        .sup        (sup),
        .fetch_side (iside),
        .hits       (fwd_hits),
        .res        (fwd_res)
    );

    bat_pick #(.N_ENT(N_ENT), .W(FWD_W)) u_fwd_pick (
        .req (fwd_hits),
        .pay (fwd_res),
        .any (hit),
        .sel (fwd_sel)
    );

    assign pa         = fwd_sel[FWD_W-1 -: ADDR_W];
    assign wimg       = fwd_sel[ATTR_W:1];
    assign sel_rw     = fwd_sel[0];
    assign prot_fault = hit & (acc == ACC_WRITE) & ~sel_rw;

    bat_rev_match #(.N_ENT(N_ENT)) u_rev (
        .pairs (d_pairs),
        .rpa   (rpa),
        .hits  (rev_hits),
        .res   (rev_res)
    );

    bat_pick #(.N_ENT(N_ENT), .W(ADDR_W)) u_rev_pick (
        .req (rev_hits),
        .pay (rev_res),
        .any (rev_any),
        .sel (rea)
    );

    logic unused_top;
    assign unused_top = rev_any;
endmodule

// File: rtl/bat_unit_chk.sv
// Property checker for bat_unit, attached by bind. Assumes size-aligned bases and
// only the three defined access codes.
module bat_unit_chk
    import bat_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   ea,
    input logic [1:0]          acc,
    input logic                iside,
    input logic                hit,
    input logic [ADDR_W-1:0]   pa,
    input logic [ATTR_W-1:0]   wimg,
    input logic                prot_fault,
    input logic [ADDR_W-1:0]   rpa,
    input logic [ADDR_W-1:0]   rea
);
    logic rst_prev = 1'b0;

    // Remember whether reset was asserted at the previous edge.
    always_ff @(posedge clk) rst_prev <= !rst_n;

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_prev |-> (!hit && rea == '0));

    a_r5_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pa[BLK_SHIFT-1:0] == ea[BLK_SHIFT-1:0]));

    a_r8_fault_only_on_write_hit: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (hit && acc == ACC_WRITE));

    a_r9_no_guarded_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && iside) |-> !wimg[0]);

    a_r10_reverse_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rea != '0) |-> (rea[BLK_SHIFT-1:0] == rpa[BLK_SHIFT-1:0]));

    a_r11_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (pa == '0 && wimg == '0 && !prot_fault));
endmodule

bind bat_unit bat_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ea         (ea),
    .acc        (acc),
    .iside      (iside),
    .hit        (hit),
    .pa         (pa),
    .wimg       (wimg),
    .prot_fault (prot_fault),
    .rpa        (rpa),
    .rea        (rea)
);

// File: tb/bat_unit_tb.sv
// Self-checking bench: programs entries, walks a vector table, then directed cases.
module bat_unit_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        sup;
        logic [1:0]  acc;
        logic        iside;
        logic [31:0] ea;
        logic        hit;
        logic [31:0] pa;
        logic [3:0]  wimg;
        logic        flt;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    // Entries: D0 C0000000/256K sup RW M -> 00040000; D1 C0000000/16M both RO I,G -> 01000000;
    // D2 80000000/128K user RW W -> 20000000; I0 like D1 (guarded); I1 00000000/128K sup RO M -> 00600000.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'b00, 1'b0, 32'hC001_0000, 1'b1, 32'h0005_0000, 4'b0010, 1'b0, 8'd6},  // R6 D0 beats D1
        '{1'b1, 2'b01, 1'b0, 32'hC001_0000, 1'b1, 32'h0005_0000, 4'b0010, 1'b0, 8'd8},  // R8 RW write
        '{1'b1, 2'b00, 1'b0, 32'hC003_FFFF, 1'b1, 32'h0007_FFFF, 4'b0010, 1'b0, 8'd4},  // R4 last byte
        '{1'b1, 2'b00, 1'b0, 32'hC004_0000, 1'b1, 32'h0104_0000, 4'b0101, 1'b0, 8'd7},  // R7 D1 attrs
        '{1'b1, 2'b01, 1'b0, 32'hC004_0000, 1'b1, 32'h0104_0000, 4'b0101, 1'b1, 8'd8},  // R8 RO write
        '{1'b0, 2'b00, 1'b0, 32'hC001_0000, 1'b1, 32'h0101_0000, 4'b0101, 1'b0, 8'd3},  // R3 user skips D0
        '{1'b1, 2'b00, 1'b0, 32'hC0FF_FFFF, 1'b1, 32'h01FF_FFFF, 4'b0101, 1'b0, 8'd5},  // R5 far offset
        '{1'b1, 2'b00, 1'b0, 32'hC100_0000, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 8'd11}, // R11 miss
        '{1'b0, 2'b01, 1'b0, 32'h8000_0010, 1'b1, 32'h2000_0010, 4'b1000, 1'b0, 8'd3},  // R3 user entry
        '{1'b1, 2'b00, 1'b0, 32'h8000_0010, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 8'd3},  // R3 sup invalid
        '{1'b0, 2'b00, 1'b0, 32'h8001_FFFF, 1'b1, 32'h2001_FFFF, 4'b1000, 1'b0, 8'd4},  // R4 128K top
        '{1'b0, 2'b00, 1'b0, 32'h8002_0000, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 8'd4},  // R4 one past
        '{1'b1, 2'b10, 1'b1, 32'hC004_0000, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 8'd9},  // R9 guarded fetch
        '{1'b1, 2'b10, 1'b1, 32'h0000_1234, 1'b1, 32'h0060_1234, 4'b0010, 1'b0, 8'd2},  // R2 I side
        '{1'b1, 2'b00, 1'b0, 32'h0000_1234, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 8'd2},  // R2 D side
        '{1'b1, 2'b01, 1'b1, 32'h0000_1234, 1'b1, 32'h0060_1234, 4'b0010, 1'b1, 8'd8},  // R8 RO I entry
        '{1'b0, 2'b10, 1'b1, 32'h0000_1234, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 8'd3}   // R3 user fetch
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_iside = 1'b0;
    logic        wr_lower = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ea = '0;
    logic        sup = 1'b0;
    logic [1:0]  acc = 2'b00;
    logic        iside = 1'b0;
    logic [31:0] rpa = '0;
    logic        hit;
    logic [31:0] pa;
    logic [3:0]  wimg;
    logic        prot_fault;
    logic [31:0] rea;

    int n_chk = 0;
    int n_bad = 0;

    bat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_iside(wr_iside),
        .wr_lower(wr_lower), .wr_data(wr_data), .ea(ea), .sup(sup), .acc(acc),
        .iside(iside), .hit(hit), .pa(pa), .wimg(wimg), .prot_fault(prot_fault),
        .rpa(rpa), .rea(rea)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic side, input logic low, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_iside = side; wr_lower = low; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic s, input logic [1:0] a, input logic side, input logic [31:0] addr);
        @(negedge clk);
        sup = s; acc = a; iside = side; ea = addr;
        #1;
    endtask

    task automatic rev(input logic [31:0] p);
        @(negedge clk);
        rpa = p;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing valid straight after reset
        look(1'b1, 2'b00, 1'b0, 32'hC001_0000);
        check("R1 hit after reset", {31'b0, hit}, 32'd0);
        rev(32'h0005_0000);
        check("R1 rea after reset", rea, 32'd0);

        // Program entries (R2 word-by-word writes)
        wr(2'd0, 1'b0, 1'b0, 32'hC000_0006);
        wr(2'd0, 1'b0, 1'b1, 32'h0004_0012);
        wr(2'd1, 1'b0, 1'b0, 32'hC000_01FF);
        wr(2'd1, 1'b0, 1'b1, 32'h0100_0029);
        wr(2'd2, 1'b0, 1'b0, 32'h8000_0001);
        wr(2'd2, 1'b0, 1'b1, 32'h2000_0042);
        wr(2'd0, 1'b1, 1'b0, 32'hC000_01FF);
        wr(2'd0, 1'b1, 1'b1, 32'h0100_0029);
        wr(2'd1, 1'b1, 1'b0, 32'h0000_0002);
        wr(2'd1, 1'b1, 1'b1, 32'h0060_0011);

        for (int i = 0; i < NV; i++) begin
            string tg;
            look(VEC[i].sup, VEC[i].acc, VEC[i].iside, VEC[i].ea);
            tg = $sformatf("R%0d vec%0d", VEC[i].req, i);
            check({tg, " hit"}, {31'b0, hit}, {31'b0, VEC[i].hit});
            check({tg, " pa"}, pa, VEC[i].pa);
            check({tg, " wimg"}, {28'b0, wimg}, {28'b0, VEC[i].wimg});
            check({tg, " fault"}, {31'b0, prot_fault}, {31'b0, VEC[i].flt});
        end

        // R10: reverse lookups through data-side windows
        rev(32'h0005_0000);
        check("R10 rev D0", rea, 32'hC001_0000);
        rev(32'h0104_0000);
        check("R10 rev D1", rea, 32'hC004_0000);
        rev(32'h2000_0010);
        check("R10 rev D2", rea, 32'h8000_0010);
        rev(32'h0060_0000);
        check("R10 rev instr-only window", rea, 32'd0);
        rev(32'h3000_0000);
        check("R10 rev no window", rea, 32'd0);

        // R6 and R2: clearing D0 valid bits hands the overlap to D1
        wr(2'd0, 1'b0, 1'b0, 32'hC000_0004);
        look(1'b1, 2'b00, 1'b0, 32'hC001_0000);
        check("R6 fallback hit", {31'b0, hit}, 32'd1);
        check("R6 fallback pa", pa, 32'h0101_0000);
        rev(32'h0005_0000);
        check("R10 rev invalid entry", rea, 32'd0);

        // R1: mid-run reset empties every entry
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(1'b1, 2'b00, 1'b0, 32'hC004_0000);
        check("R1 hit after second reset", {31'b0, hit}, 32'd0);
        check("R11 pa after second reset", pa, 32'd0);
        look(1'b1, 2'b10, 1'b1, 32'h0000_1234);
        check("R1 fetch after second reset", {31'b0, hit}, 32'd0);
        rev(32'h0104_0000);
        check("R1 rea after second reset", rea, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule